// File: doc/BRIEF.md
# I/O Port Access Unit

This block carries out the port input and port output operations of a CPU model. The execution stage hands it one request at a time. A request carries the direction, the transfer width, the current accumulator value and the port number. The port number is either an 8-bit immediate or the 16-bit DX register. The unit checks whether the access is allowed, then runs a single transfer on a simple I/O bus. For an input it returns the updated accumulator.

Devices see only the low ten bits of the port number, so any port at 1024 or above lands on a port in 0..1023. In protected mode, a request from a privilege level numerically above the I/O privilege level never reaches the bus. Instead the unit raises a one-cycle general-protection fault. The unit has no flags output, so flags cannot change.

Top module: `io_port_unit`

## Requirements
- R1: With `req_use_dx` = 0 the port number is `req_imm8` zero-extended to 16 bits, so only ports 0..255 are reachable. With `req_use_dx` = 1 the port number is `req_dx`.
- R2: `io_addr` carries bits [9:0] of the selected port number, so port P and port P+1024·k reach the same device address.
- R3: `req_size` encodes the width: 0 is byte (AL), 1 is word (AX), 2 and 3 are doubleword (EAX). During an access, `io_be` is 0001, 0011 or 1111 respectively; it is 0000 when no access is running.
- R4: For an output (`req_dir_out` = 1), `io_wdata` carries the enabled low bytes of the accumulator and zero in every disabled byte, and `io_wr` is the strobe.
- R5: For an input, the completed accumulator takes the enabled low bytes from `io_rdata` and keeps every other byte of the requested accumulator. It appears on `acc_out` with `acc_we` = 1.
- R6: The strobe, address, enables and write data stay constant from the cycle after acceptance until the cycle in which `io_ready` is sampled high. `done` pulses for exactly the following cycle, and the strobe is low in that cycle.
- R7: When `prot_mode` = 1 and `cpl` > `iopl`, the request raises `gp_fault` for exactly the next cycle. It produces no strobe, no `done` and no `acc_we`.
- R8: In real mode, or in protected mode with `cpl` ≤ `iopl`, the request performs the bus access normally.
- R9: `req_valid` is ignored while `busy` is high, including in the cycle in which `io_ready` ends the current access.
- R10: After reset, `io_rd`, `io_wr`, `io_be`, `done`, `acc_we`, `gp_fault` and `busy` are all low.
- R11: `io_rd` and `io_wr` are never high together.
- R12: `acc_we` is high only in a `done` cycle that ends an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a port access |
| req_dir_out | input | 1 | 1 for output, 0 for input |
| req_use_dx | input | 1 | Take port number from DX instead of the immediate |
| req_imm8 | input | 8 | Immediate port number |
| req_dx | input | 16 | DX register value |
| req_size | input | 2 | Width code: 0 byte, 1 word, 2/3 doubleword |
| req_acc | input | 32 | Accumulator value at request |
| prot_mode | input | 1 | Protected mode active |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| io_addr | output | 10 | Decoded device address |
| io_be | output | 4 | Byte-lane enables |
| io_rd | output | 1 | Read strobe |
| io_wr | output | 1 | Write strobe |
| io_wdata | output | 32 | Write data |
| io_rdata | input | 32 | Read data from device |
| io_ready | input | 1 | Device completes the access |
| busy | output | 1 | An access is running |
| done | output | 1 | One-cycle completion pulse |
| acc_we | output | 1 | Accumulator write enable |
| acc_out | output | 32 | Updated accumulator |
| gp_fault | output | 1 | One-cycle general-protection fault |

## Verification
Two functions can collide. A new request can arrive in the same cycle in which the device's ready ends the running access, and a request can arrive while the strobe is waiting for ready. The bench raises `req_valid` with a different port and direction in both cycles. It then judges that the address stays put during the wait, that exactly one `done` follows, and that no strobe appears in the cycles after completion. Privilege-gated requests are mixed into the same random stream, so faults are checked directly before and after normal bus accesses.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } xfer_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } ctl_state_e;

    // number of low bytes a width code moves
    function automatic int unsigned size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = 1;
            SZ_WORD: size_bytes = 2;
            default: size_bytes = 4;
        endcase
    endfunction

endpackage

// File: rtl/io_port_sel.sv
module io_port_sel #(
    parameter int PORT_W = 16,
    parameter int IMM_W  = 8,
    parameter int DEC_W  = 10
) (
    input  logic              use_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PORT_W-1:0] reg_port,
    output logic [PORT_W-1:0] port_full,
    output logic [DEC_W-1:0]  port_dec
);
    localparam int PAD_W = PORT_W - IMM_W;

    logic [PORT_W-1:0] imm_ext;

    always_comb begin
        imm_ext   = {{PAD_W{1'b0}}, imm};
        port_full = use_reg ? reg_port : imm_ext;
        port_dec  = port_full[DEC_W-1:0];
    end

endmodule

// File: rtl/io_priv_gate.sv
module io_priv_gate #(
    parameter int PL_W = 2
) (
    input  logic            prot_mode,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] iopl,
    output logic            allow
);
    logic too_low;

    always_comb begin
        too_low = (cpl > iopl);
        allow   = !(prot_mode && too_low);
    end

endmodule

// File: rtl/io_lane_ctl.sv
module io_lane_ctl
    import io_port_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]          size,
    input  logic [DATA_W-1:0]   acc_src,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] hold_be,
    input  logic [DATA_W-1:0]   hold_acc,
    input  logic [DATA_W-1:0]   rdata,
    output logic [DATA_W-1:0]   merged
);
    localparam int LANES = DATA_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            be[i]              = (i < size_bytes(size));
            wdata[8*i +: 8]    = be[i] ? acc_src[8*i +: 8] : 8'h00;
            merged[8*i +: 8]   = hold_be[i] ? rdata[8*i +: 8] : hold_acc[8*i +: 8];
        end
    end

endmodule

// File: rtl/io_port_unit.sv
module io_port_unit
    import io_port_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int IMM_W  = 8,
    parameter int DEC_W  = 10,
    parameter int DATA_W = 32,
    parameter int PL_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_dir_out,
    input  logic                req_use_dx,
    input  logic [IMM_W-1:0]    req_imm8,
    input  logic [PORT_W-1:0]   req_dx,
    input  logic [1:0]          req_size,
    input  logic [DATA_W-1:0]   req_acc,
    input  logic                prot_mode,
    input  logic [PL_W-1:0]     cpl,
    input  logic [PL_W-1:0]     iopl,
    output logic [DEC_W-1:0]    io_addr,
    output logic [DATA_W/8-1:0] io_be,
    output logic                io_rd,
    output logic                io_wr,
    output logic [DATA_W-1:0]   io_wdata,
    input  logic [DATA_W-1:0]   io_rdata,
    input  logic                io_ready,
    output logic                busy,
    output logic                done,
    output logic                acc_we,
    output logic [DATA_W-1:0]   acc_out,
    output logic                gp_fault
);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        ctl_state_e         st;
        logic               is_out;
        logic [DEC_W-1:0]   addr;
        logic [LANES-1:0]   be;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  acc;
        logic [DATA_W-1:0]  acc_res;
        logic               done;
        logic               we;
        logic               fault;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, is_out: 1'b0, addr: '0, be: '0, wdata: '0,
        acc: '0, acc_res: '0, done: 1'b0, we: 1'b0, fault: 1'b0
    };

    regs_t d, q;

    logic [PORT_W-1:0] port_full;
    logic [DEC_W-1:0]  port_dec;
    logic              allow;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] lane_wdata;
    logic [DATA_W-1:0] lane_merged;

    io_port_sel #(.PORT_W(PORT_W), .IMM_W(IMM_W), .DEC_W(DEC_W)) u_sel (
        .use_reg   (req_use_dx),
        .imm       (req_imm8),
        .reg_port  (req_dx),
        .port_full (port_full),
        .port_dec  (port_dec)
    );

    io_priv_gate #(.PL_W(PL_W)) u_priv (
        .prot_mode (prot_mode),
        .cpl       (cpl),
        .iopl      (iopl),
        .allow     (allow)
    );

    io_lane_ctl #(.DATA_W(DATA_W)) u_lane (
        .size     (req_size),
        .acc_src  (req_acc),
        .be       (lane_be),
        .wdata    (lane_wdata),
        .hold_be  (q.be),
        .hold_acc (q.acc),
        .rdata    (io_rdata),
        .merged   (lane_merged)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.we    = 1'b0;
        d.fault = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!allow) begin
                        d.fault = 1'b1;
                    end else begin
                        d.st     = ST_BUS;
                        d.is_out = req_dir_out;
                        d.addr   = port_dec;
                        d.be     = lane_be;
                        d.wdata  = lane_wdata;
                        d.acc    = req_acc;
                    end
                end
            end
            ST_BUS: begin
                if (io_ready) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if (!q.is_out) begin
                        d.we      = 1'b1;
                        d.acc_res = lane_merged;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    always_comb begin
        busy     = (q.st == ST_BUS);
        io_rd    = busy && !q.is_out;
        io_wr    = busy && q.is_out;
        io_addr  = q.addr;
        io_be    = busy ? q.be : '0;
        io_wdata = io_wr ? q.wdata : '0;
        done     = q.done;
        acc_we   = q.we;
        acc_out  = q.acc_res;
        gp_fault = q.fault;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));                                              // R11

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && !io_ready) |=>
        ((io_rd || io_wr) && $stable(io_addr) && $stable(io_be)));     // R6

    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && io_ready) |=> (done && !io_rd && !io_wr)); // R6

    AST_FAULT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> (!io_rd && !io_wr && !done && !acc_we));           // R7

    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |=> !gp_fault);                                         // R7

    AST_WE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_ready) |=> acc_we);                                 // R12

    AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> done);                                                // R12

    AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (io_be == '0));                                        // R3

endmodule

// File: tb/io_port_unit_tb.sv
module io_port_unit_tb;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        req_valid, req_dir_out, req_use_dx;
    logic [7:0]  req_imm8;
    logic [15:0] req_dx;
    logic [1:0]  req_size;
    logic [31:0] req_acc;
    logic        prot_mode;
    logic [1:0]  cpl, iopl;
    logic [9:0]  io_addr;
    logic [3:0]  io_be;
    logic        io_rd, io_wr;
    logic [31:0] io_wdata, io_rdata;
    logic        io_ready;
    logic        busy, done, acc_we, gp_fault;
    logic [31:0] acc_out;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    io_port_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir_out(req_dir_out),
        .req_use_dx(req_use_dx), .req_imm8(req_imm8), .req_dx(req_dx),
        .req_size(req_size), .req_acc(req_acc), .prot_mode(prot_mode),
        .cpl(cpl), .iopl(iopl), .io_addr(io_addr), .io_be(io_be),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_ready(io_ready), .busy(busy), .done(done), .acc_we(acc_we),
        .acc_out(acc_out), .gp_fault(gp_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_addr(input bit use_dx, input logic [7:0] imm,
                                            input logic [15:0] dxv);
        logic [15:0] p;
        p = use_dx ? dxv : {8'h00, imm};
        return p[9:0];
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] exp_merge(input logic [1:0] sz, input logic [31:0] acc,
                                              input logic [31:0] rd);
        return (rd & lane_mask(sz)) | (acc & ~lane_mask(sz));
    endfunction

    task automatic run_op(input bit out, input bit use_dx, input logic [7:0] imm,
                          input logic [15:0] dxv, input logic [1:0] sz,
                          input logic [31:0] acc, input bit pm, input logic [1:0] c,
                          input logic [1:0] pl, input int wait_n, input bit poke,
                          input logic [31:0] rd);
        bit    allow;
        string tg;
        allow = !pm || (c <= pl);
        tg    = pm ? "R8" : (use_dx ? "R2" : "R1");
        @(negedge clk);
        req_valid = 1'b1; req_dir_out = out; req_use_dx = use_dx; req_imm8 = imm;
        req_dx = dxv; req_size = sz; req_acc = acc; prot_mode = pm; cpl = c; iopl = pl;
        @(negedge clk);
        req_valid = 1'b0;
        if (!allow) begin
            chk(gp_fault == 1'b1, "R7 fault pulse", {31'd0, gp_fault}, 32'd1);
            chk(!io_rd && !io_wr && !busy, "R7 no strobe", {30'd0, io_rd, io_wr}, 32'd0);
            @(negedge clk);
            chk(!gp_fault && !done && !acc_we && !io_rd && !io_wr, "R7 fault ends",
                {28'd0, gp_fault, done, acc_we, io_rd | io_wr}, 32'd0);
            return;
        end
        chk(io_rd == !out && io_wr == out, {tg, " strobe R11"}, {30'd0, io_rd, io_wr},
            {30'd0, !out, out});
        chk(io_addr == exp_addr(use_dx, imm, dxv), {tg, " address"}, {22'd0, io_addr},
            {22'd0, exp_addr(use_dx, imm, dxv)});
        chk(io_be == exp_be(sz), "R3 byte enables", {28'd0, io_be}, {28'd0, exp_be(sz)});
        if (out)
            chk(io_wdata == (acc & lane_mask(sz)), "R4 write data", io_wdata,
                acc & lane_mask(sz));
        for (int i = 0; i < wait_n; i++) begin
            if (i == 0 && poke) begin
                req_valid = 1'b1; req_use_dx = 1'b1; req_dx = ~dxv; req_dir_out = ~out;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk((io_rd || io_wr) && io_addr == exp_addr(use_dx, imm, dxv) && !done,
                "R6 R9 held while waiting", {22'd0, io_addr},
                {22'd0, exp_addr(use_dx, imm, dxv)});
        end
        io_ready = 1'b1;
        io_rdata = rd;
        if (poke) begin
            req_valid = 1'b1; req_use_dx = 1'b1; req_dx = dxv ^ 16'h0155; req_dir_out = ~out;
        end
        @(negedge clk);
        io_ready = 1'b0;
        req_valid = 1'b0;
        chk(done == 1'b1 && !io_rd && !io_wr, "R6 done after ready",
            {30'd0, done, io_rd | io_wr}, 32'd2);
        if (!out)
            chk(acc_we && acc_out == exp_merge(sz, acc, rd), "R5 read merge", acc_out,
                exp_merge(sz, acc, rd));
        else
            chk(!acc_we, "R12 no write on output", {31'd0, acc_we}, 32'd0);
        @(negedge clk);
        chk(!done && !acc_we && !io_rd && !io_wr && !busy, "R9 single completion",
            {28'd0, done, acc_we, io_rd | io_wr, busy}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_dir_out = 1'b0; req_use_dx = 1'b0;
        req_imm8 = '0; req_dx = '0; req_size = '0; req_acc = '0; prot_mode = 1'b0;
        cpl = '0; iopl = '0; io_rdata = '0; io_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!io_rd && !io_wr && io_be == 4'd0 && !done && !acc_we && !gp_fault && !busy,
            "R10 reset outputs", {25'd0, io_rd, io_wr, io_be == 4'd0, done, acc_we,
            gp_fault, busy}, 32'h0000_0010);
        rst_n = 1'b1;

        // directed corners
        run_op(1'b0, 1'b0, 8'hFF, 16'h0000, 2'd0, 32'hA1B2C3D4, 1'b0, 2'd0, 2'd0, 0, 1'b0,
               32'h11223344);                                        // R1 top immediate
        run_op(1'b0, 1'b1, 8'h00, 16'h0400, 2'd1, 32'hDEADBEEF, 1'b0, 2'd0, 2'd0, 2, 1'b0,
               32'h55667788);                                        // R2 alias to 0
        run_op(1'b1, 1'b1, 8'h00, 16'hFFFF, 2'd2, 32'hCAFEF00D, 1'b0, 2'd0, 2'd0, 1, 1'b0,
               32'h0);                                               // R2 alias to 3FF
        run_op(1'b1, 1'b0, 8'h60, 16'h0000, 2'd3, 32'h01020304, 1'b0, 2'd0, 2'd0, 0, 1'b0,
               32'h0);                                               // R3 code 3
        run_op(1'b1, 1'b0, 8'h80, 16'h0000, 2'd0, 32'hFFFFFF5A, 1'b0, 2'd0, 2'd0, 0, 1'b0,
               32'h0);                                               // R4 byte zeroing
        run_op(1'b0, 1'b1, 8'h00, 16'h03F8, 2'd0, 32'h12345678, 1'b1, 2'd3, 2'd0, 0, 1'b0,
               32'h0);                                               // R7 fault
        run_op(1'b0, 1'b1, 8'h00, 16'h03F8, 2'd1, 32'h12345678, 1'b1, 2'd2, 2'd2, 1, 1'b0,
               32'h9ABCDEF0);                                        // R8 equal levels
        run_op(1'b0, 1'b0, 8'h21, 16'h0000, 2'd2, 32'h0, 1'b0, 2'd3, 2'd0, 0, 1'b0,
               32'h0BADCAFE);                                        // R8 real mode
        run_op(1'b0, 1'b1, 8'h00, 16'h1234, 2'd0, 32'h87654321, 1'b0, 2'd0, 2'd0, 3, 1'b1,
               32'h000000AB);                                        // R9 collisions
        run_op(1'b1, 1'b1, 8'h00, 16'h8001, 2'd1, 32'h13572468, 1'b0, 2'd0, 2'd0, 0, 1'b1,
               32'h0);                                               // R9 ready-cycle request

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0] c, pl;
            bit pm;
            pm = ($urandom_range(0, 2) == 0);
            c  = 2'($urandom_range(0, 3));
            pl = 2'($urandom_range(0, 3));
            run_op(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                   8'($urandom), 16'($urandom), 2'($urandom_range(0, 3)), $urandom,
                   pm, c, pl, int'($urandom_range(0, 4)),
                   ($urandom_range(0, 3) == 0), $urandom);
        end

        repeat (2) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule